// File: doc/BRIEF.md
# Global Counter Enable and Overflow Status Unit

This block sits beside a set of performance counters and gives software one place to start and stop them and one place to find out which of them has wrapped. It serves two general-purpose counters and three fixed counters. Three 64-bit registers sit behind a simple register port. The enable register turns on any mix of counters in a single write, and each of its implemented bits drives the global enable wire of one counter. The status register gathers sticky flags. Each counter has an overflow flag. There is also a flag for a precise-sampling buffer event and a flag raised when the monitoring configuration changes. The clear register never holds data: each 1 written to it drops the status flag at the same bit position.

The counters themselves sit outside this unit. They report wraps as one-cycle pulses and receive their enables from it. Reads are combinational from the registered state. A write takes effect at the clock edge where it is presented, so the new value is visible from the following cycle.

Top module: `counterGlobalUnit`

## Requirements
- R1: After reset every enable output is 0, and the enable and status registers both read as zero.
- R2: A write to address 0 loads all enables at once. Data bit 0 drives general counter 0 and bit 1 drives general counter 1. Bits 32, 33 and 34 drive fixed counters 0, 1 and 2. Reading address 0 returns exactly those bits, and every other bit reads 0.
- R3: An overflow pulse on a counter sets its status flag from the next cycle on. General counters use bits 0 and 1 and fixed counters use bits 32 to 34 of address 1. The flag stays set until it is cleared.
- R4: A pulse on the buffer-event input sets status bit 62. A pulse on the configuration-change input sets status bit 63. Both flags are sticky.
- R5: A write to address 2 clears every status flag whose bit position holds a 1 in the written data. Flags at positions holding 0 are unchanged.
- R6: When a set event and a clear hit the same flag in the same cycle, the flag ends up set.
- R7: The status register at address 1 is read-only: a write there changes no flag and no enable.
- R8: Address 2 always reads zero. Address 3 reads zero, and a write to it has no effect.
- R9: Status bits other than 0, 1, 32 to 34, 62 and 63 always read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| wrEn | input | 1 | Write strobe for the register port |
| regAddr | input | 2 | Register select: 0 enable, 1 status, 2 clear, 3 unused |
| wrData | input | 64 | Write data |
| rdData | output | 64 | Read data for the register selected by regAddr |
| gpOvf | input | 2 | Overflow pulses from the general counters |
| fixOvf | input | 3 | Overflow pulses from the fixed counters |
| bufEvent | input | 1 | Buffer-overflow event pulse from the sampling logic |
| cfgChange | input | 1 | Monitoring-configuration-changed pulse |
| gpEnable | output | 2 | Global enables to the general counters |
| fixEnable | output | 3 | Global enables to the fixed counters |

## Verification
Directed cases come first. Single-counter pulses show that each source lands at its own bit position. An all-ones enable write shows that reserved positions are masked. A clear of a partial set shows that flags are cleared one by one and not all together. A clear that meets a pulse in the same cycle separates set priority from clear priority. Writes to the status address and the unused address show that these writes are dropped. The random phase then mixes random writes to every address with random pulse combinations. Each cycle's status and enable state is compared with a bench model, which catches wrong ordering between stickiness, set and clear.

// File: rtl/gcuPkg.sv
package gcuPkg;

  localparam int REG_W    = 64;
  localparam int GP_BASE  = 0;
  localparam int FIX_BASE = 32;
  localparam int BUF_BIT  = 62;
  localparam int CHG_BIT  = 63;

  typedef enum logic [1:0] {
    SEL_ENABLE = 2'd0,
    SEL_STATUS = 2'd1,
    SEL_CLEAR  = 2'd2,
    SEL_NONE   = 2'd3
  } regSel_e;

  typedef struct packed {
    logic    enWrite;
    logic    clrWrite;
    regSel_e rdSel;
  } strobe_t;

endpackage

// File: rtl/gcuControl.sv
module gcuControl
  import gcuPkg::*;
(
  input  logic       wrEn,
  input  logic [1:0] regAddr,
  output strobe_t    strb
);

  regSel_e sel;

  always_comb begin
    case (regAddr)
      2'd0:    sel = SEL_ENABLE;
      2'd1:    sel = SEL_STATUS;
      2'd2:    sel = SEL_CLEAR;
      default: sel = SEL_NONE;
    endcase
  end

  always_comb begin
    strb.rdSel    = sel;
    strb.enWrite  = wrEn && (sel == SEL_ENABLE);
    strb.clrWrite = wrEn && (sel == SEL_CLEAR);
  end

endmodule

// File: rtl/gcuDatapath.sv
module gcuDatapath
  import gcuPkg::*;
#(
  parameter int NUM_GP  = 2,
  parameter int NUM_FIX = 3
) (
  input  logic               clk,
  input  logic               rst,
  input  strobe_t            strb,
  input  logic [REG_W-1:0]   wrData,
  input  logic [NUM_GP-1:0]  gpOvf,
  input  logic [NUM_FIX-1:0] fixOvf,
  input  logic               bufEvent,
  input  logic               cfgChange,
  output logic [NUM_GP-1:0]  gpEnable,
  output logic [NUM_FIX-1:0] fixEnable,
  output logic [REG_W-1:0]   statusVec,
  output logic [REG_W-1:0]   rdData
);

  localparam int NUM_CTR = NUM_GP + NUM_FIX;

  logic [NUM_CTR-1:0] enReg;
  logic [NUM_CTR-1:0] ovfReg;
  logic               bufFlag;
  logic               chgFlag;

  logic [NUM_CTR-1:0] wrCtr;
  logic [NUM_CTR-1:0] setCtr;
  logic [REG_W-1:0]   enWord;

  // Gather write data and event pulses into per-counter vectors.
  always_comb begin
    wrCtr  = '0;
    setCtr = '0;
    for (int g = 0; g < NUM_GP; g++) begin
      wrCtr[g]  = wrData[GP_BASE + g];
      setCtr[g] = gpOvf[g];
    end
    for (int f = 0; f < NUM_FIX; f++) begin
      wrCtr[NUM_GP + f]  = wrData[FIX_BASE + f];
      setCtr[NUM_GP + f] = fixOvf[f];
    end
  end

  // Enable register
  always_ff @(posedge clk) begin
    if (rst)               enReg <= '0;
    else if (strb.enWrite) enReg <= wrCtr;
  end

  // Sticky status flags: a set in the same cycle overrides a clear.
  always_ff @(posedge clk) begin
    if (rst) begin
      ovfReg  <= '0;
      bufFlag <= 1'b0;
      chgFlag <= 1'b0;
    end else begin
      ovfReg  <= (ovfReg & ~(strb.clrWrite ? wrCtr : '0)) | setCtr;
      bufFlag <= (bufFlag & ~(strb.clrWrite & wrData[BUF_BIT])) | bufEvent;
      chgFlag <= (chgFlag & ~(strb.clrWrite & wrData[CHG_BIT])) | cfgChange;
    end
  end

  // Scatter per-counter state back into register images.
  always_comb begin
    enWord    = '0;
    statusVec = '0;
    for (int g = 0; g < NUM_GP; g++) begin
      enWord[GP_BASE + g]    = enReg[g];
      statusVec[GP_BASE + g] = ovfReg[g];
    end
    for (int f = 0; f < NUM_FIX; f++) begin
      enWord[FIX_BASE + f]    = enReg[NUM_GP + f];
      statusVec[FIX_BASE + f] = ovfReg[NUM_GP + f];
    end
    statusVec[BUF_BIT] = bufFlag;
    statusVec[CHG_BIT] = chgFlag;
  end

  always_comb begin
    case (strb.rdSel)
      SEL_ENABLE: rdData = enWord;
      SEL_STATUS: rdData = statusVec;
      default:    rdData = '0;
    endcase
  end

  assign gpEnable  = enReg[NUM_GP-1:0];
  assign fixEnable = enReg[NUM_CTR-1:NUM_GP];

endmodule

// File: rtl/counterGlobalUnit.sv
module counterGlobalUnit
  import gcuPkg::*;
#(
  parameter int NUM_GP  = 2,
  parameter int NUM_FIX = 3
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wrEn,
  input  logic [1:0]         regAddr,
  input  logic [REG_W-1:0]   wrData,
  output logic [REG_W-1:0]   rdData,
  input  logic [NUM_GP-1:0]  gpOvf,
  input  logic [NUM_FIX-1:0] fixOvf,
  input  logic               bufEvent,
  input  logic               cfgChange,
  output logic [NUM_GP-1:0]  gpEnable,
  output logic [NUM_FIX-1:0] fixEnable
);

  strobe_t          strb;
  logic [REG_W-1:0] statusVec;

  gcuControl u_ctrl (
    .wrEn    (wrEn),
    .regAddr (regAddr),
    .strb    (strb)
  );

  gcuDatapath #(
    .NUM_GP  (NUM_GP),
    .NUM_FIX (NUM_FIX)
  ) u_data (
    .clk       (clk),
    .rst       (rst),
    .strb      (strb),
    .wrData    (wrData),
    .gpOvf     (gpOvf),
    .fixOvf    (fixOvf),
    .bufEvent  (bufEvent),
    .cfgChange (cfgChange),
    .gpEnable  (gpEnable),
    .fixEnable (fixEnable),
    .statusVec (statusVec),
    .rdData    (rdData)
  );

endmodule

// File: rtl/counterGlobalUnitChecker.sv
module counterGlobalUnitChecker
  import gcuPkg::*;
#(
  parameter int NUM_GP  = 2,
  parameter int NUM_FIX = 3
) (
  input logic               clk,
  input logic               rst,
  input logic               wrEn,
  input logic [1:0]         regAddr,
  input logic [REG_W-1:0]   wrData,
  input logic [REG_W-1:0]   rdData,
  input logic [NUM_GP-1:0]  gpOvf,
  input logic [NUM_FIX-1:0] fixOvf,
  input logic               bufEvent,
  input logic               cfgChange,
  input logic [NUM_GP-1:0]  gpEnable,
  input logic [NUM_FIX-1:0] fixEnable,
  input logic [REG_W-1:0]   statusVec
);

  logic [REG_W-1:0] setMask;
  logic [REG_W-1:0] implMask;
  logic [REG_W-1:0] clrMask;
  logic [NUM_GP-1:0]  wrGp;
  logic [NUM_FIX-1:0] wrFix;

  always_comb begin
    setMask  = '0;
    implMask = '0;
    wrGp     = '0;
    wrFix    = '0;
    for (int g = 0; g < NUM_GP; g++) begin
      setMask[GP_BASE + g]  = gpOvf[g];
      implMask[GP_BASE + g] = 1'b1;
      wrGp[g]               = wrData[GP_BASE + g];
    end
    for (int f = 0; f < NUM_FIX; f++) begin
      setMask[FIX_BASE + f]  = fixOvf[f];
      implMask[FIX_BASE + f] = 1'b1;
      wrFix[f]               = wrData[FIX_BASE + f];
    end
    setMask[BUF_BIT]  = bufEvent;
    setMask[CHG_BIT]  = cfgChange;
    implMask[BUF_BIT] = 1'b1;
    implMask[CHG_BIT] = 1'b1;
    clrMask = (wrEn && regAddr == 2'd2) ? (wrData & implMask) : '0;
  end

  // R1: leaving reset, all enables and flags are clear
  assert_reset_clear_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (gpEnable == '0 && fixEnable == '0 && statusVec == '0));

  // R2: enable write reaches the enable outputs
  assert_enable_load_R2: assert property (@(posedge clk) disable iff (rst)
    (wrEn && regAddr == 2'd0) |=> (gpEnable == $past(wrGp) && fixEnable == $past(wrFix)));

  // R3, R4, R6: any set event is visible in the next cycle, clear or not
  assert_set_lands_R3: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((statusVec & $past(setMask)) == $past(setMask)));

  // R3: flags not cleared stay set
  assert_sticky_hold_R3: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((statusVec & $past(statusVec) & ~$past(clrMask)) ==
              ($past(statusVec) & ~$past(clrMask))));

  // R5: cleared flags without a competing set go low
  assert_clear_drops_R5: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((statusVec & $past(clrMask) & ~$past(setMask)) == '0));

  // R7: enables change only through an address-0 write
  assert_enable_stable_R7: assert property (@(posedge clk) disable iff (rst)
    !(wrEn && regAddr == 2'd0) |=> ($stable(gpEnable) && $stable(fixEnable)));

  // R8: clear and unused addresses read as zero
  assert_zero_read_R8: assert property (@(posedge clk) disable iff (rst)
    (regAddr[1] == 1'b1) |-> (rdData == '0));

  // R9: reserved status positions are never set
  assert_reserved_zero_R9: assert property (@(posedge clk) disable iff (rst)
    ((statusVec & ~implMask) == '0));

endmodule

bind counterGlobalUnit counterGlobalUnitChecker #(
  .NUM_GP  (NUM_GP),
  .NUM_FIX (NUM_FIX)
) chk (
  .clk       (clk),
  .rst       (rst),
  .wrEn      (wrEn),
  .regAddr   (regAddr),
  .wrData    (wrData),
  .rdData    (rdData),
  .gpOvf     (gpOvf),
  .fixOvf    (fixOvf),
  .bufEvent  (bufEvent),
  .cfgChange (cfgChange),
  .gpEnable  (gpEnable),
  .fixEnable (fixEnable),
  .statusVec (statusVec)
);

// File: tb/counterGlobalUnit_test.sv
`timescale 1ns/1ps
module counterGlobalUnit_test;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wrEn = 1'b0;
  logic [1:0]  regAddr = 2'd0;
  logic [63:0] wrData = '0;
  logic [63:0] rdData;
  logic [1:0]  gpOvf = '0;
  logic [2:0]  fixOvf = '0;
  logic        bufEvent = 1'b0;
  logic        cfgChange = 1'b0;
  logic [1:0]  gpEnable;
  logic [2:0]  fixEnable;

  int testsRun = 0;
  int testsFailed = 0;
  bit finished = 1'b0;

  logic [4:0]  expEn = '0;
  logic [63:0] expStat = '0;

  localparam logic [63:0] IMPL = 64'hC000_0007_0000_0003;

  always #2.5 clk = ~clk;

  counterGlobalUnit uut (
    .clk(clk), .rst(rst), .wrEn(wrEn), .regAddr(regAddr), .wrData(wrData),
    .rdData(rdData), .gpOvf(gpOvf), .fixOvf(fixOvf), .bufEvent(bufEvent),
    .cfgChange(cfgChange), .gpEnable(gpEnable), .fixEnable(fixEnable)
  );

  function automatic logic [63:0] setMaskOf(logic [1:0] g, logic [2:0] f, logic b, logic c);
    return {c, b, 27'b0, f, 30'b0, g};
  endfunction

  function automatic logic [63:0] enWordOf(logic [4:0] e);
    return {29'b0, e[4:2], 30'b0, e[1:0]};
  endfunction

  function automatic logic [4:0] enFromData(logic [63:0] d);
    return {d[34:32], d[1:0]};
  endfunction

  task automatic check(string req, string what, logic [63:0] act, logic [63:0] exp);
    testsRun++;
    if (act !== exp) begin
      testsFailed++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // Called just after a falling edge; ends just after the next falling edge.
  task automatic doCycle(logic we, logic [1:0] a, logic [63:0] d,
                         logic [1:0] g, logic [2:0] f, logic b, logic c);
    logic [63:0] clr;
    wrEn = we; regAddr = a; wrData = d;
    gpOvf = g; fixOvf = f; bufEvent = b; cfgChange = c;
    clr = (we && a == 2'd2) ? (d & IMPL) : '0;
    @(posedge clk);
    if (we && a == 2'd0) expEn = enFromData(d);
    expStat = (expStat & ~clr) | setMaskOf(g, f, b, c);
    @(negedge clk);
    wrEn = 1'b0; gpOvf = '0; fixOvf = '0; bufEvent = 1'b0; cfgChange = 1'b0;
  endtask

  task automatic checkState(string req);
    wrEn = 1'b0;
    regAddr = 2'd1; #0.5;
    check(req, "status", rdData, expStat);
    regAddr = 2'd0; #0.5;
    check(req, "enable readback", rdData, enWordOf(expEn));
    check(req, "enable outputs", {59'b0, fixEnable, gpEnable}, {59'b0, expEn});
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) doCycle(1'b0, 2'd0, '0, '0, '0, 1'b0, 1'b0);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    expEn = '0; expStat = '0;
    checkState("R1");

    // R2: all-ones enable write, reserved bits masked
    doCycle(1'b1, 2'd0, '1, '0, '0, 1'b0, 1'b0);
    checkState("R2");
    check("R2", "enable image", rdData, 64'h0000_0007_0000_0003);
    doCycle(1'b1, 2'd0, 64'h0000_0002_0000_0001, '0, '0, 1'b0, 1'b0);
    checkState("R2");

    // R3: single overflows, then persistence
    doCycle(1'b0, 2'd0, '0, 2'b01, 3'b100, 1'b0, 1'b0);
    checkState("R3");
    idle(4);
    checkState("R3");
    regAddr = 2'd1; #0.5;
    check("R3", "sticky bits", rdData, 64'h0000_0004_0000_0001);

    // R4: buffer and config-change flags
    doCycle(1'b0, 2'd0, '0, '0, '0, 1'b1, 1'b0);
    doCycle(1'b0, 2'd0, '0, '0, '0, 1'b0, 1'b1);
    checkState("R4");
    regAddr = 2'd1; #0.5;
    check("R4", "flags 62/63", rdData & 64'hC000_0000_0000_0000, 64'hC000_0000_0000_0000);

    // R5: partial clear
    doCycle(1'b1, 2'd2, 64'h4000_0004_0000_0000, '0, '0, 1'b0, 1'b0);
    checkState("R5");
    regAddr = 2'd1; #0.5;
    check("R5", "partial clear", rdData, 64'h8000_0000_0000_0001);

    // R6: clear and set same cycle
    doCycle(1'b1, 2'd2, '1, 2'b10, '0, 1'b0, 1'b1);
    checkState("R6");
    regAddr = 2'd1; #0.5;
    check("R6", "set wins", rdData, 64'h8000_0000_0000_0002);

    // R7: write to status ignored
    doCycle(1'b1, 2'd1, '1, '0, '0, 1'b0, 1'b0);
    checkState("R7");
    doCycle(1'b1, 2'd1, '0, '0, '0, 1'b0, 1'b0);
    checkState("R7");

    // R8: clear and unused addresses
    regAddr = 2'd2; #0.5;
    check("R8", "clear readback", rdData, '0);
    regAddr = 2'd3; #0.5;
    check("R8", "unused readback", rdData, '0);
    doCycle(1'b1, 2'd3, '1, '0, '0, 1'b0, 1'b0);
    checkState("R8");

    // R9: all events at once, reserved stays zero
    doCycle(1'b0, 2'd0, '0, 2'b11, 3'b111, 1'b1, 1'b1);
    checkState("R9");
    regAddr = 2'd1; #0.5;
    check("R9", "reserved bits", rdData & ~IMPL, '0);

    // Random mix across R2..R8
    for (int i = 0; i < 400; i++) begin
      logic [63:0] d;
      d = {$urandom(), $urandom()};
      doCycle(($urandom() % 2) == 0, 2'($urandom()), d, 2'($urandom()),
              3'($urandom()), ($urandom() % 8) == 0, ($urandom() % 8) == 0);
      checkState("R5");
    end

    finished = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

  initial begin
    #100000;
    if (!finished) begin
      testsRun++;
      testsFailed++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  end

endmodule